// File: doc/BRIEF.md
# Two-Channel Autosweep Mux Sequencer

This block picks which of two analog inputs a successive-approximation converter samples in its next frame. The host frames each transfer with an active-low select window, and the length of that window is the only control the block has. While the window is open, the block counts serial-clock ticks and records whether the converter reported the end of its conversion after the last data clock. When the window closes, one of three things happens. A short window of four to seven ticks forces the selection back to input 0. A complete frame, meaning all sixteen ticks followed by a finished conversion, swaps to the other input. Any other window leaves the selection as it was.

The converter returns each result one frame after it takes the sample. The block therefore also drives a result tag. At each complete frame the tag takes the channel that was selected during that frame, so it always names the source of the word being shifted out in the current frame. The serial clock and the window arrive already synchronised to the system clock, as a one-cycle tick strobe and a level. The analog switch itself lies outside the block.

Top module: `sweep_mux_seq`

## Requirements
- R1: After reset, the channel select and the result tag both read 0 (input 0).
- R2: A window that holds between 4 and 7 serial-clock ticks inclusive sets the channel select to 0 when it closes, whatever its previous value. The result tag does not change.
- R3: A window that holds 16 or more ticks, and in which the end-of-conversion strobe arrives after the 16th tick, inverts the channel select when it closes.
- R4: The channel select and the result tag change only in the system-clock cycle that follows the close of a window, which is the low-to-high transition of the active-low select. They hold steady while a window is open and while the select is idle.
- R5: A window with fewer than 4 ticks, including one with no ticks at all, leaves the channel select and the tag unchanged.
- R6: A window of 8 to 15 ticks, or one of 16 or more ticks in which no end-of-conversion strobe arrives, leaves the channel select and the tag unchanged.
- R7: An end-of-conversion strobe that arrives before the 16th tick of the window is ignored.
- R8: When a window completes as described in R3, the result tag takes the channel select value that was in force during that window. The tag therefore labels the result that is shifted out in the following window.
- R9: Ticks and end-of-conversion strobes that arrive while the select is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Synchronised chip-select/frame-sync; low means the window is open |
| sclkTick | input | 1 | One-cycle strobe for each counted serial-clock edge |
| convDone | input | 1 | One-cycle strobe when the converter finishes a conversion |
| chanSel | output | 1 | Channel the converter samples (0 = input 0, 1 = input 1) |
| resultChan | output | 1 | Channel that produced the result now being shifted out |

## Verification
The bench builds the block with its default parameters: a reset band of 4 to 7 ticks and a frame length of 16 ticks. These values put the edges of every window class within a few dozen cycles, so the bench can reach each of them directly: 0, 3, 4, 7, 8, 10 and 16 ticks, and a window that runs past the point where the tick counter saturates. The bench places the end-of-conversion strobe on either side of the 16th tick, and it starts short windows from both select values so that a forced return to input 0 can be told apart from a hold.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

  // Strobes from the window control to the channel datapath
  typedef struct packed {
    logic winOpen;   // select is low this cycle
    logic winStart;  // first cycle of a new window
    logic doReset;   // force input 0
    logic doToggle;  // swap input and retag
  } seqStrobe_t;

endpackage

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
  import sweep_pkg::*;
#(
  parameter int RST_MIN     = 4,
  parameter int RST_MAX     = 7,
  parameter int FRAME_TICKS = 16,
  parameter int CNT_W       = $clog2(FRAME_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic [CNT_W-1:0] winCnt,
  input  logic             convSeen,
  input  logic             chanSel,
  input  logic             resultChan,
  output seqStrobe_t       strb
);

  logic csPrev;
  logic closeEdge;
  logic inResetBand;
  logic fullFrame;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) csPrev <= 1'b1;
    else       csPrev <= csN;
  end

  assign closeEdge   = csN & ~csPrev;
  assign inResetBand = (winCnt >= CNT_W'(RST_MIN)) && (winCnt <= CNT_W'(RST_MAX));
  assign fullFrame   = (winCnt >= CNT_W'(FRAME_TICKS)) && convSeen;

  always_comb begin
    strb          = '0;
    strb.winOpen  = ~csN;
    strb.winStart = ~csN & csPrev;
    strb.doReset  = closeEdge & inResetBand;
    strb.doToggle = closeEdge & fullFrame & ~inResetBand;
  end

  AST_RESET_BAND: assert property (@(posedge clk) disable iff (!rstN)
    (closeEdge && inResetBand) |=> !chanSel);  // R2
  AST_FULL_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    (closeEdge && fullFrame) |=> (chanSel != $past(chanSel)));  // R3
  AST_TAG_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (closeEdge && fullFrame) |=> (resultChan == $past(chanSel)));  // R8
  AST_SHORT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (closeEdge && winCnt < CNT_W'(RST_MIN)) |=> $stable(chanSel));  // R5
  AST_MID_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (closeEdge && winCnt > CNT_W'(RST_MAX) && !fullFrame) |=> ($stable(chanSel) && $stable(resultChan)));  // R6

endmodule

// File: rtl/sweep_dp.sv
module sweep_dp
  import sweep_pkg::*;
#(
  parameter int FRAME_TICKS = 16,
  parameter int CNT_W       = $clog2(FRAME_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strb,
  input  logic             sclkTick,
  input  logic             convDone,
  output logic [CNT_W-1:0] winCnt,
  output logic             convSeen,
  output logic             chanSel,
  output logic             resultChan
);

  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(FRAME_TICKS);

  // Tick counter and completion flag for the open window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt   <= '0;
      convSeen <= 1'b0;
    end else if (strb.winStart) begin
      winCnt   <= sclkTick ? CNT_W'(1) : '0;
      convSeen <= 1'b0;
    end else if (strb.winOpen) begin
      if (sclkTick && winCnt < CNT_TOP) winCnt <= winCnt + 1'b1;
      if (convDone && winCnt == CNT_TOP) convSeen <= 1'b1;
    end
  end

  // Channel select and one-frame-late result tag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanSel    <= 1'b0;
      resultChan <= 1'b0;
    end else if (strb.doReset) begin
      chanSel    <= 1'b0;
    end else if (strb.doToggle) begin
      chanSel    <= ~chanSel;
      resultChan <= chanSel;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    winCnt <= CNT_TOP);  // R6
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.doReset || strb.doToggle) |=> ($stable(chanSel) && $stable(resultChan)));  // R4
  AST_EARLY_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.winOpen && !strb.winStart && convDone && winCnt < CNT_TOP && !convSeen) |=> !convSeen);  // R7

endmodule

// File: rtl/sweep_mux_seq.sv
module sweep_mux_seq
  import sweep_pkg::*;
#(
  parameter int RST_MIN     = 4,
  parameter int RST_MAX     = 7,
  parameter int FRAME_TICKS = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sclkTick,
  input  logic convDone,
  output logic chanSel,
  output logic resultChan
);

  localparam int CNT_W = $clog2(FRAME_TICKS + 1);

  seqStrobe_t       strb;
  logic [CNT_W-1:0] winCnt;
  logic             convSeen;

  sweep_ctrl #(
    .RST_MIN(RST_MIN), .RST_MAX(RST_MAX), .FRAME_TICKS(FRAME_TICKS), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .winCnt(winCnt), .convSeen(convSeen),
    .chanSel(chanSel), .resultChan(resultChan), .strb(strb)
  );

  sweep_dp #(
    .FRAME_TICKS(FRAME_TICKS), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sclkTick(sclkTick), .convDone(convDone),
    .winCnt(winCnt), .convSeen(convSeen), .chanSel(chanSel), .resultChan(resultChan)
  );

endmodule

// File: tb/sweep_mux_seq_bench.sv
module sweep_mux_seq_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclkTick = 1'b0;
  logic convDone = 1'b0;
  logic chanSel;
  logic resultChan;

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;

  always #2 clk = ~clk;

  sweep_mux_seq u_sweep_mux_seq (
    .clk(clk), .rstN(rstN), .csN(csN), .sclkTick(sclkTick), .convDone(convDone),
    .chanSel(chanSel), .resultChan(resultChan)
  );

  localparam int NV = 15;
  // ticks in window, done strobe after tick N (0 = none), expected select, expected tag
  localparam int vTicks [NV] = '{16, 16, 20, 7, 3, 16, 3, 10, 16, 16, 4, 8, 16, 0, 4};
  localparam int vDone  [NV] = '{16, 16, 20, 0, 0, 16, 0, 0,  0,  10, 0, 0, 16, 0, 0};
  localparam int vSel   [NV] = '{1,  0,  1,  0, 0, 1,  1, 1,  1,  1,  0, 0, 1,  1, 0};
  localparam int vTag   [NV] = '{0,  1,  0,  0, 0, 0,  0, 0,  0,  0,  0, 0, 0,  0, 0};
  localparam string vReq [NV] = '{"R3", "R8", "R3", "R2", "R5", "R3", "R5", "R6",
                                   "R6", "R7", "R2", "R6", "R8", "R5", "R2"};

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulseTick();
    sclkTick = 1'b1;
    @(negedge clk);
    sclkTick = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulseDone();
    convDone = 1'b1;
    @(negedge clk);
    convDone = 1'b0;
    @(negedge clk);
  endtask

  task automatic openWindow(input int ticks, input int doneAfter);
    csN = 1'b0;
    @(negedge clk);
    for (int i = 1; i <= ticks; i++) begin
      pulseTick();
      if (i == doneAfter) pulseDone();
    end
  endtask

  task automatic closeWindow();
    csN = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 sel", int'(chanSel), 0);
    check("R1 tag", int'(resultChan), 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      openWindow(vTicks[v], vDone[v]);
      closeWindow();
      check($sformatf("%s sel v%0d", vReq[v], v), int'(chanSel), vSel[v]);
      check($sformatf("%s tag v%0d", vReq[v], v), int'(resultChan), vTag[v]);
    end

    // R4: no change while a completing window is still open
    openWindow(16, 16);
    repeat (3) @(negedge clk);
    check("R4 sel open", int'(chanSel), 0);
    check("R4 tag open", int'(resultChan), 0);
    closeWindow();
    check("R3 sel after", int'(chanSel), 1);
    check("R8 tag after", int'(resultChan), 0);

    // R9: ticks and done strobes while idle
    for (int i = 0; i < 20; i++) pulseTick();
    pulseDone();
    check("R9 sel idle", int'(chanSel), 1);
    check("R9 tag idle", int'(resultChan), 0);

    // R9: idle activity must not let a short window reach the reset band
    for (int i = 0; i < 5; i++) pulseTick();
    openWindow(2, 0);
    closeWindow();
    check("R9 sel short", int'(chanSel), 1);

    // R1: reset again from a non-zero state
    openWindow(16, 16);
    closeWindow();
    check("R8 tag pre-reset", int'(resultChan), 1);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 sel rerst", int'(chanSel), 0);
    check("R1 tag rerst", int'(resultChan), 0);

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule